// File: doc/BRIEF.md
# Per-Pin Input Debounce Filter

This block sits between each pin's synchronized input level and the logic that uses it, such as edge detection. It has one filter per pin. When a pin's filter is on, a new input level reaches the output only after the input has held that level, unbroken, for a stable window. Software sets the window as a power-of-two number of milliseconds, from 1 ms to 128 ms, with a 3-bit exponent for each pin. A shared prescaler divides the system clock down to a one-cycle pulse once per millisecond, and every pin uses that pulse as its time base.

Each pin also has an enable bit. When the enable is low, the filter is bypassed completely and the raw level passes straight to the output. When the enable or the exponent changes, any count in progress starts again from zero, so a new setting never inherits time measured under an old one. The register decode that supplies the enable and exponent lives outside this block. So does the edge detection that consumes the filtered level.

Top module: `pin_debounce_array`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, each pin's filtered output equals that pin's raw input level.
- R2: When a pin's enable is 0, its filtered output equals its raw input in the same cycle, with no register delay.
- R3: When a pin's enable is 1 with exponent n (3 bits, unsigned), the output takes a new level only after the raw input has differed from it for 2^n consecutive millisecond ticks. With P clock cycles per tick, a level held for (2^n − 1)·P cycles or fewer has not yet passed. A level held for 2^n·P + 1 cycles has passed.
- R4: If the raw input returns to the output level before the window completes, the count is discarded, and a later change must again last a full window.
- R5: Clearing a pin's enable while a count is in progress makes the output follow the raw input at once. The pending count is discarded.
- R6: Any change to a pin's exponent or enable restarts that pin's count from zero.
- R7: The millisecond tick is high for exactly one cycle in every CLKS_PER_MS clock cycles. Its first pulse comes CLKS_PER_MS cycles after reset is released.
- R8: Pins are independent: activity on one pin's input or settings never changes another pin's output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| raw_i | input | NUM_PINS | Synchronized raw pin levels |
| dbnc_en_i | input | NUM_PINS | Per-pin filter enable (0 = bypass) |
| dbnc_exp_i | input | NUM_PINS x 3 | Per-pin window exponent n; window is 2^n ms |
| filt_o | output | NUM_PINS | Filtered pin levels |
| ms_tick_o | output | 1 | One-cycle pulse per millisecond from the shared prescaler |

## Verification
The bench drives level changes of several lengths against windows of 1, 4, 8 and 128 ticks. It holds each change either for one tick less than the window, which must not pass, or just past the window, which must pass. This separates a correct count from an off-by-one or a wrong power of two. Glitch patterns check that the count restarts when the input falls back to the output level. A one-cycle detour of the exponent in the middle of a count checks that a settings change restarts the count; a filter that only accumulates would let the level through early. Bypass toggles are sampled inside the same cycle to tell a combinational path from a registered one. Every check compares the whole output vector, which shows whether any pin disturbed another.

// File: rtl/dbnc_pkg.sv
package dbnc_pkg;

    // Width of the per-pin window exponent
    localparam int EXP_W = 3;
    // Counter width able to hold the largest window, 2^(2^EXP_W - 1)
    localparam int CNT_W = 1 << EXP_W;

    typedef logic [EXP_W-1:0] exp_t;
    typedef logic [CNT_W-1:0] cnt_t;

    // Settings that, when changed, restart a pin's count
    typedef struct packed {
        logic enable;
        exp_t expo;
    } pin_cfg_t;

    // Per-pin filter state
    typedef struct packed {
        logic level;
        cnt_t ticks;
    } pin_state_t;

    // Number of millisecond ticks in the stable window for exponent e
    function automatic cnt_t window_ticks(input exp_t e);
        return cnt_t'(1) << e;
    endfunction

endpackage

// File: rtl/ms_prescaler.sv
module ms_prescaler #(
    parameter int CLKS_PER_MS = 250000
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic tick_o
);

    localparam int DIV_W = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
    localparam logic [DIV_W-1:0] LAST = DIV_W'(CLKS_PER_MS - 1);

    logic [DIV_W-1:0] div_q;

    assign tick_o = (div_q == LAST);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            div_q <= '0;
        end else if (tick_o) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

endmodule

// File: rtl/pin_debounce.sv
module pin_debounce
    import dbnc_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic tick_i,
    input  logic raw_i,
    input  logic en_i,
    input  exp_t exp_i,
    output logic filt_o
);

    pin_state_t st_q;
    pin_state_t st_d;
    pin_cfg_t   cfg_q;
    pin_cfg_t   cfg_now;
    logic       cfg_changed;
    logic [CNT_W:0] ticks_inc;
    cnt_t       win;

    assign cfg_now     = '{enable: en_i, expo: exp_i};
    assign cfg_changed = (cfg_now != cfg_q);
    assign win         = window_ticks(exp_i);
    assign ticks_inc   = {1'b0, st_q.ticks} + 1'b1;

    always_comb begin
        st_d = st_q;
        if (!en_i) begin
            st_d.level = raw_i;
            st_d.ticks = '0;
        end else if (cfg_changed || (raw_i == st_q.level)) begin
            st_d.ticks = '0;
        end else if (tick_i) begin
            if (ticks_inc >= {1'b0, win}) begin
                st_d.level = raw_i;
                st_d.ticks = '0;
            end else begin
                st_d.ticks = ticks_inc[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.level <= raw_i;
            st_q.ticks <= '0;
            cfg_q      <= cfg_now;
        end else begin
            st_q  <= st_d;
            cfg_q <= cfg_now;
        end
    end

    assign filt_o = en_i ? st_q.level : raw_i;

endmodule

// File: rtl/pin_debounce_array.sv
module pin_debounce_array
    import dbnc_pkg::*;
#(
    parameter int NUM_PINS    = 8,
    parameter int CLKS_PER_MS = 250000
) (
    input  logic                           clk_i,
    input  logic                           rst_i,
    input  logic [NUM_PINS-1:0]            raw_i,
    input  logic [NUM_PINS-1:0]            dbnc_en_i,
    input  logic [NUM_PINS-1:0][EXP_W-1:0] dbnc_exp_i,
    output logic [NUM_PINS-1:0]            filt_o,
    output logic                           ms_tick_o
);

    logic tick;

    ms_prescaler #(
        .CLKS_PER_MS(CLKS_PER_MS)
    ) presc_i (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .tick_o(tick)
    );

    assign ms_tick_o = tick;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        pin_debounce filt_i (
            .clk_i (clk_i),
            .rst_i (rst_i),
            .tick_i(tick),
            .raw_i (raw_i[p]),
            .en_i  (dbnc_en_i[p]),
            .exp_i (dbnc_exp_i[p]),
            .filt_o(filt_o[p])
        );
    end

endmodule

// File: rtl/pin_debounce_array_chk.sv
module pin_debounce_array_chk
    import dbnc_pkg::*;
#(
    parameter int NUM_PINS    = 8,
    parameter int CLKS_PER_MS = 250000
) (
    input logic                           clk_i,
    input logic                           rst_i,
    input logic [NUM_PINS-1:0]            raw_i,
    input logic [NUM_PINS-1:0]            dbnc_en_i,
    input logic [NUM_PINS-1:0][EXP_W-1:0] dbnc_exp_i,
    input logic [NUM_PINS-1:0]            filt_o,
    input logic                           ms_tick_o
);

    // R7: tick never lasts two cycles when the divider is above one
    p_tick_single_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (ms_tick_o && (CLKS_PER_MS > 1)) |=> !ms_tick_o);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_chk
        // R2: a disabled pin shows its raw level
        p_bypass_r2: assert property (@(posedge clk_i) disable iff (rst_i)
            !dbnc_en_i[p] |-> (filt_o[p] == raw_i[p]));

        // R3: with settings steady, an enabled output moves only after a tick, to the raw level
        p_flip_on_tick_r3: assert property (@(posedge clk_i) disable iff (rst_i)
            (dbnc_en_i[p] && $past(dbnc_en_i[p]) && $stable(dbnc_exp_i[p])
             && (filt_o[p] != $past(filt_o[p])))
            |-> ($past(ms_tick_o) && (filt_o[p] == $past(raw_i[p]))));

        // R4: a raw level equal to the output keeps the enabled output still
        p_hold_on_match_r4: assert property (@(posedge clk_i) disable iff (rst_i)
            (dbnc_en_i[p] && $past(dbnc_en_i[p]) && $past(raw_i[p] == filt_o[p]))
            |-> $stable(filt_o[p]));
    end

endmodule

bind pin_debounce_array pin_debounce_array_chk #(
    .NUM_PINS   (NUM_PINS),
    .CLKS_PER_MS(CLKS_PER_MS)
) chk_i (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .raw_i     (raw_i),
    .dbnc_en_i (dbnc_en_i),
    .dbnc_exp_i(dbnc_exp_i),
    .filt_o    (filt_o),
    .ms_tick_o (ms_tick_o)
);

// File: tb/pin_debounce_array_tb_top.sv
`timescale 1ns/100ps
module pin_debounce_array_tb_top;
    import dbnc_pkg::*;

    localparam int NP  = 4;
    localparam int DIV = 4;

    logic                    clk;
    logic                    rst;
    logic [NP-1:0]           raw;
    logic [NP-1:0]           en;
    logic [NP-1:0][EXP_W-1:0] expv;
    logic [NP-1:0]           filt;
    logic                    tick;

    pin_debounce_array #(
        .NUM_PINS   (NP),
        .CLKS_PER_MS(DIV)
    ) dut_i (
        .clk_i     (clk),
        .rst_i     (rst),
        .raw_i     (raw),
        .dbnc_en_i (en),
        .dbnc_exp_i(expv),
        .filt_o    (filt),
        .ms_tick_o (tick)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    typedef struct {
        logic [NP-1:0] want;
        string         tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    event     sb_ev;
    int       n_checks = 0;
    int       n_errors = 0;
    bit       finished = 0;

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    // Monitor: pops expected items and compares against the outputs
    initial begin
        forever begin
            @(sb_ev);
            while (sb_q.size() != 0) begin
                sb_item_t it;
                it = sb_q.pop_front();
                n_checks++;
                if (filt !== it.want) begin
                    n_errors++;
                    $display("FAIL %s: filt_o actual=%b expected=%b", it.tag, filt, it.want);
                end
            end
        end
    end

    // Driver side: queue an expectation and hand it to the monitor
    task automatic expect_out(input logic [NP-1:0] want, input string tag);
        sb_item_t it;
        it.want = want;
        it.tag  = tag;
        sb_q.push_back(it);
        #0.5;
        -> sb_ev;
        #0.5;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int ticks_seen;
        raw  = 4'b1010;
        en   = 4'b1111;
        expv[0] = 3'd2;   // 4 ticks
        expv[1] = 3'd0;   // 1 tick
        expv[2] = 3'd3;   // 8 ticks
        expv[3] = 3'd7;   // 128 ticks
        rst  = 1'b1;
        cyc(5);
        expect_out(4'b1010, "R1 during reset");
        rst = 1'b0;
        cyc(1);
        expect_out(4'b1010, "R1 after reset");

        // R7: tick count over 40 cycles
        ticks_seen = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (tick) ticks_seen++;
        end
        n_checks++;
        if (ticks_seen != 40 / DIV) begin
            n_errors++;
            $display("FAIL R7 tick count: actual=%0d expected=%0d", ticks_seen, 40 / DIV);
        end

        // R3/R8: pin0 window 4, held long enough
        raw[0] = 1'b1;
        cyc(3 * DIV);
        expect_out(4'b1010, "R3 pin0 short hold");
        cyc(DIV + 1);
        expect_out(4'b1011, "R3 pin0 full window R8");

        // R3: pin2 window 8
        raw[2] = 1'b1;
        cyc(7 * DIV);
        expect_out(4'b1011, "R3 pin2 short hold");
        cyc(DIV + 1);
        expect_out(4'b1111, "R3 pin2 full window");

        // R3: pin1 window 1
        raw[1] = 1'b0;
        cyc(DIV + 1);
        expect_out(4'b1101, "R3 pin1 one tick");

        // R3: pin3 window 128
        raw[3] = 1'b0;
        cyc(127 * DIV);
        expect_out(4'b1101, "R3 pin3 short hold");
        cyc(DIV + 1);
        expect_out(4'b0101, "R3 pin3 full window");

        // R4: glitch on pin0 restarts the count
        raw[0] = 1'b0;
        cyc(8);
        raw[0] = 1'b1;
        cyc(2);
        expect_out(4'b0101, "R4 glitch returned");
        raw[0] = 1'b0;
        cyc(3 * DIV);
        expect_out(4'b0101, "R4 restart holds");
        cyc(DIV + 1);
        expect_out(4'b0100, "R4 full window after restart");

        // R6: exponent detour restarts pin2 count
        raw[2] = 1'b0;
        cyc(20);
        expv[2] = 3'd2;
        cyc(1);
        expv[2] = 3'd3;
        cyc(7 * DIV);
        expect_out(4'b0100, "R6 restart after exponent change");
        cyc(DIV + 2);
        expect_out(4'b0000, "R6 full window after restart");

        // R5: disable pin3 mid-count
        raw[3] = 1'b1;
        cyc(10);
        en[3] = 1'b0;
        expect_out(4'b1000, "R5 disable mid-count");
        cyc(1);

        // R2: bypass is immediate
        raw[3] = 1'b0;
        expect_out(4'b0000, "R2 bypass low");
        cyc(1);
        raw[3] = 1'b1;
        expect_out(4'b1000, "R2 bypass high");
        cyc(1);

        // R6: re-enable restarts count on pin3
        en[3] = 1'b1;
        cyc(1);
        expect_out(4'b1000, "R6 re-enable keeps level");
        raw[3] = 1'b0;
        cyc(4 * DIV);
        expect_out(4'b1000, "R6 re-enabled pin3 holds");

        cyc(2);
        finish_run();
    end

endmodule